// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bank

This block gathers up to 32 interrupt lines into a single interrupt request for a processor. Every line has a status bit that is latched when the line fires, an enable bit that masks it, and a pending view that is the AND of the two. Software reads a vector register to find the number of the most urgent pending line, handles it, and clears the latched bit by writing a one to its position in the acknowledge register.

Each line is either edge-sensitive or level-sensitive. A parameter bit mask sets this when the block is built: a one selects edge. An edge line latches on a rising edge of its synchronously sampled input. A level line latches on every cycle its input is high, so a level request that software acknowledges too early comes straight back. The request output is gated by a two-bit master enable. The upper bit of the master enable cannot be cleared once it has been set, except by reset.

Software reaches the block through a plain synchronous register port with a 3-bit word address, a write strobe, write data and combinational read data.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The word address selects a register as follows: 0 status (read only), 1 pending (read only), 2 enable (read/write), 3 acknowledge (write only, reads 0), 4 set-enable (write only), 5 clear-enable (write only), 6 vector (read only), 7 master enable (read/write, bits 1:0).
- R2: A write to address 4 ORs the data into the enable bits. A write to address 5 clears the enable bits where the data has ones. All other enable bits keep their value.
- R3: A write to address 3 clears every status bit whose data bit is one. Writing all ones clears all latched requests.
- R4: The vector register reads the index of the lowest-numbered bit set in pending, zero-extended to 32 bits. It reads 0xFFFFFFFF when pending is zero.
- R5: Master enable bit 0 follows the written value. Bit 1 is set by writing a one to it and stays set until reset. The request output is high only when pending is non-zero and both bits are one.
- R6: An edge source sets its status bit only on a low-to-high change between two consecutive clock samples. Holding the input high after an acknowledge does not set the bit again.
- R7: A level source whose input is still high on the cycle it is acknowledged keeps its status bit set.
- R8: Writing zero to the enable register masks every source (pending zero, request low) without changing the status bits.
- R9: When an acknowledge and a new rising edge hit the same edge source in the same cycle, the status bit stays set.
- R10: After reset, status, enable and master enable are zero, the vector reads 0xFFFFFFFF and the request output is low.
- R11: Status, pending and enable bits at positions NUM_SRC and above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Interrupt source lines |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A source input that is high at clock edge k shows in status, pending, vector and the request output just after edge k. A register write is sampled at one edge and its effect can be read just after that edge. Read data is combinational from state, so a read is valid one nanosecond after the address changes. The bench drives all inputs on falling edges and samples just before the next rising edge, so every check sees exactly one register update. The vector sweep goes through all 256 enable patterns of an 8-source build and computes the expected lowest index with a loop.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int unsigned BUS_W  = 32;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned MAX_SRC = 32;

   typedef enum logic [ADDR_W-1:0] {
      RG_STAT   = 3'd0,
      RG_PEND   = 3'd1,
      RG_EN     = 3'd2,
      RG_ACK    = 3'd3,
      RG_ENSET  = 3'd4,
      RG_ENCLR  = 3'd5,
      RG_VEC    = 3'd6,
      RG_MASTER = 3'd7
   } vic_reg_e;

   localparam logic [BUS_W-1:0] VEC_NONE = '1;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
   parameter int unsigned  N_SRC     = 32,
   parameter logic [31:0]  EDGE_MASK = 32'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   input  logic [N_SRC-1:0] ack_i,
   output logic [N_SRC-1:0] stat_o
);
   logic [N_SRC-1:0] src_q;
   logic [N_SRC-1:0] hit;

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_i;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (EDGE_MASK[i]) begin : g_edge
         assign hit[i] = src_i[i] & ~src_q[i];

         a_r6_edge_no_resample: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat_o[i] && !(src_i[i] && !src_q[i])) |=> !stat_o[i]);
         a_r9_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[i] && src_i[i] && !src_q[i]) |=> stat_o[i]);
      end else begin : g_level
         assign hit[i] = src_i[i];

         a_r7_level_relatch: assert property (@(posedge clk) disable iff (!rst_n)
            src_i[i] |=> stat_o[i]);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) stat_o[i] <= 1'b0;
         else        stat_o[i] <= (stat_o[i] & ~ack_i[i]) | hit[i];
      end
   end
endmodule

// File: rtl/vic_enable.sv
module vic_enable #(
   parameter int unsigned N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_all,
   input  logic             wr_set,
   input  logic             wr_clr,
   input  logic [N_SRC-1:0] wdata,
   output logic [N_SRC-1:0] en_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      en_o <= '0;
      else if (wr_all) en_o <= wdata;
      else if (wr_set) en_o <= en_o | wdata;
      else if (wr_clr) en_o <= en_o & ~wdata;
   end

   a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((en_o & $past(wdata)) == '0));
   a_r2_set_adds: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en_o & $past(wdata)) == $past(wdata)));
   a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en_o & $past(en_o)) == $past(en_o)));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
   parameter int unsigned N_SRC = 32,
   parameter int unsigned OUT_W = 32
) (
   input  logic [N_SRC-1:0] pend_i,
   output logic [OUT_W-1:0] vec_o
);
   always_comb begin
      vec_o = '1;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (pend_i[i]) vec_o = OUT_W'(i);
      end
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int unsigned NUM_SRC   = 32,
   parameter logic [31:0] EDGE_MASK = 32'h0000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [2:0]         bus_addr,
   input  logic               bus_we,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_o
);
   import vic_pkg::*;

   initial begin
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC)
         $error("vec_irq_ctrl: NUM_SRC must be 1..%0d", MAX_SRC);
   end

   logic [NUM_SRC-1:0] stat, en, pend, ack;
   logic [BUS_W-1:0]   vec;
   logic [BUS_W-1:0]   stat_w, en_w, pend_w;
   logic               me_run, me_arm;
   vic_reg_e           sel;

   assign sel  = vic_reg_e'(bus_addr);
   assign ack  = (bus_we && sel == RG_ACK) ? bus_wdata[NUM_SRC-1:0] : '0;
   assign pend = stat & en;

   vic_capture #(.N_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .ack_i(ack), .stat_o(stat));

   vic_enable #(.N_SRC(NUM_SRC)) u_en (
      .clk(clk), .rst_n(rst_n),
      .wr_all(bus_we && sel == RG_EN),
      .wr_set(bus_we && sel == RG_ENSET),
      .wr_clr(bus_we && sel == RG_ENCLR),
      .wdata(bus_wdata[NUM_SRC-1:0]),
      .en_o(en));

   vic_prio #(.N_SRC(NUM_SRC), .OUT_W(BUS_W)) u_prio (
      .pend_i(pend), .vec_o(vec));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         me_run <= 1'b0;
         me_arm <= 1'b0;
      end else if (bus_we && sel == RG_MASTER) begin
         me_run <= bus_wdata[0];
         me_arm <= me_arm | bus_wdata[1];
      end
   end

   assign irq_o = (|pend) & me_run & me_arm;

   always_comb begin
      stat_w = '0; en_w = '0; pend_w = '0;
      stat_w[NUM_SRC-1:0] = stat;
      en_w[NUM_SRC-1:0]   = en;
      pend_w[NUM_SRC-1:0] = pend;
   end

   always_comb begin
      unique case (sel)
         RG_STAT:   bus_rdata = stat_w;
         RG_PEND:   bus_rdata = pend_w;
         RG_EN:     bus_rdata = en_w;
         RG_VEC:    bus_rdata = vec;
         RG_MASTER: bus_rdata = {30'd0, me_arm, me_run};
         default:   bus_rdata = '0;
      endcase
   end

   a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (me_run && me_arm && pend != '0));
   a_r5_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      me_arm |=> me_arm);
   a_r4_vec_none: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> (vec == VEC_NONE));
   a_r4_vec_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |-> (vec < NUM_SRC && pend[vec[4:0]]));
   a_r8_mask_keeps_stat: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == RG_EN && bus_wdata == '0 && src_i == '0) |=>
      (pend == '0 && stat == $past(stat)));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
   localparam int N = 8;
   localparam logic [31:0] EMASK = 32'h0000_00F0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src = '0;
   logic [2:0]   addr = '0;
   logic         we = 1'b0;
   logic [31:0]  wdata = '0;
   logic [31:0]  rdata;
   logic         irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vec_irq_ctrl #(.NUM_SRC(N), .EDGE_MASK(EMASK)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] low_idx(input logic [N-1:0] p);
      logic [31:0] r = 32'hFFFF_FFFF;
      for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R10 reset state
      rd(3'd0, v); chk("R10 status", v, 0);
      rd(3'd2, v); chk("R10 enable", v, 0);
      rd(3'd7, v); chk("R10 master", v, 0);
      rd(3'd6, v); chk("R10 vector", v, 32'hFFFF_FFFF);
      chk("R10 irq", irq, 0);
      rd(3'd3, v); chk("R1 ack reads zero", v, 0);

      // R5 master enable, sticky upper bit
      wr(3'd7, 32'h3); rd(3'd7, v); chk("R5 master on", v, 3);
      wr(3'd7, 32'h0); rd(3'd7, v); chk("R5 bit1 sticky", v, 2);
      wr(3'd7, 32'h1); rd(3'd7, v); chk("R5 master again", v, 3);

      // R8 masked level source keeps status
      src[0] = 1'b1; tick(1); src[0] = 1'b0; tick(1);
      rd(3'd0, v); chk("R8 status latched", v, 32'h1);
      rd(3'd1, v); chk("R8 pending masked", v, 0);
      chk("R8 irq masked", irq, 0);
      wr(3'd2, 32'h1);
      rd(3'd1, v); chk("R1 pending", v, 32'h1);
      rd(3'd6, v); chk("R4 vector src0", v, 0);
      chk("R5 irq on", irq, 1);
      wr(3'd7, 32'h0);
      chk("R5 irq gated by bit0", irq, 0);
      wr(3'd7, 32'h1);
      wr(3'd3, 32'h1);
      rd(3'd0, v); chk("R3 ack clears", v, 0);
      rd(3'd6, v); chk("R4 vector none", v, 32'hFFFF_FFFF);
      chk("R5 irq drops", irq, 0);

      // R7 level held high through acknowledge
      src[0] = 1'b1; tick(1);
      wr(3'd3, 32'h1);
      rd(3'd0, v); chk("R7 level relatched", v, 32'h1);
      src[0] = 1'b0; tick(1);
      wr(3'd3, 32'h1);
      rd(3'd0, v); chk("R7 level released", v, 0);

      // R6 edge source
      src[4] = 1'b1; tick(1);
      rd(3'd0, v); chk("R6 edge latched", v, 32'h10);
      wr(3'd3, 32'h10); tick(3);
      rd(3'd0, v); chk("R6 no relatch while high", v, 0);
      src[4] = 1'b0; tick(1); src[4] = 1'b1; tick(1);
      rd(3'd0, v); chk("R6 new edge", v, 32'h10);
      src[4] = 1'b0;
      wr(3'd3, 32'h10);

      // R9 acknowledge and edge in the same cycle
      src[5] = 1'b1; tick(1); src[5] = 1'b0; tick(1);
      rd(3'd0, v); chk("R9 pre status", v, 32'h20);
      @(negedge clk);
      src[5] = 1'b1; addr = 3'd3; wdata = 32'h20; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      rd(3'd0, v); chk("R9 edge wins", v, 32'h20);
      src[5] = 1'b0;

      // R2 set/clear enable
      wr(3'd2, 32'h0F);
      wr(3'd4, 32'h30); rd(3'd2, v); chk("R2 set-enable", v, 32'h3F);
      wr(3'd5, 32'h05); rd(3'd2, v); chk("R2 clear-enable", v, 32'h3A);
      wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R11 enable upper bits", v, 32'hFF);

      // R3 acknowledge all
      src[6] = 1'b1; tick(1); src[6] = 1'b0;
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd0, v); chk("R3 ack all", v, 0);

      // R4 sweep with every source latched
      src[3:0] = 4'hF; src[7:4] = 4'hF; tick(1); src[7:4] = 4'h0; tick(1);
      rd(3'd0, v); chk("R11 status width", v, 32'hFF);
      wr(3'd7, 32'h3);
      for (int e = 0; e < 256; e++) begin
         wr(3'd2, e);
         rd(3'd6, v); chk("R4 vector sweep", v, low_idx(e[N-1:0]));
         rd(3'd1, v); chk("R1 pending sweep", v, e);
         chk("R5 irq sweep", irq, (e != 0));
      end

      // R8 enable zero keeps status
      wr(3'd2, 32'h0);
      rd(3'd0, v); chk("R8 status kept", v, 32'hFF);
      rd(3'd1, v); chk("R8 pending zero", v, 0);
      chk("R8 irq low", irq, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule